// File: doc/BRIEF.md
# Prioritized Interrupt Level Arbiter

This block decides, on each clock, whether the processor core should take an interrupt, and at which of the sixteen priority levels. It receives fifteen level-sensitive request lines for levels 1 to 15, the core's current interrupt mask level and its global trap enable bit. It presents a registered take flag together with a 4-bit level. A trap sequencer outside the block turns that level into a trap type. Level 0 means that no interrupt is present. A mask value of 0 lets every level through. Level 15 is the non-maskable level.

An optional second stage collects sixteen more sources, numbered 16 to 31. Each one sets a sticky pending bit. While any of these bits is set, the stage raises a single programmable base level, chosen from 1 to 14, into the main resolver. Software finds out which source fired by reading the identifier output, which reports the highest-numbered pending source. It then acknowledges that source with a one-cycle clear strobe.

Every request input passes through a two-flop synchronizer. The take flag and the level are plain status pins rather than a stream: they are a continuously re-evaluated decision, and they apply no back-pressure and need no handshake.

Top module: `irqarb_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `take_irq` is 0, `take_lvl` is 0, `ext_id` is 0 and `ext_any` is 0.
- R2: When several eligible levels are pending, `take_lvl` shows the highest one. `irq_req` bit i stands for level i.
- R3: A pending level that is less than or equal to `pil_mask` is never taken. When `pil_mask` is 0, every level from 1 to 15 is eligible.
- R4: Level 15 is taken whenever it is pending and `trap_en` is 1, whatever the value of `pil_mask`, including 15.
- R5: When `trap_en` is 0, `take_irq` is 0 and `take_lvl` is 0, even if level 15 is pending.
- R6: A change on `irq_req` reaches the outputs on the third rising edge after it is applied. A change on `pil_mask` or `trap_en` reaches the outputs on the first rising edge after it is applied.
- R7: When an `ext_req` line is high, its pending bit is set, and the bit stays set after the line drops. While any extended bit is pending, the level given by `ext_base` takes part in resolution like any other request.
- R8: `ext_id` reports 16 plus the index of the highest-numbered pending extended bit. It reports 0 when no extended bit is pending. `ext_any` is 1 exactly when some extended bit is pending.
- R9: A one-cycle pulse on `ext_clr` clears only the pending bit that `ext_id` reports at that edge. If the clear and a request for the same bit arrive on the same edge, the clear wins.
- R10: If `ext_base` is 0 or 15, pending extended bits raise no level. They stay pending and remain visible on `ext_id`.
- R11: A request on `ext_req` sets its pending bit on the third rising edge after it is applied, and reaches `take_irq` and `take_lvl` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to the clock |
| irq_req | input | 15 | Request lines; bit i is level i (bits 15..1) |
| pil_mask | input | 4 | Current interrupt mask level |
| trap_en | input | 1 | Global trap enable |
| ext_req | input | 16 | Extended source requests; bit k is source 16+k |
| ext_base | input | 4 | Level that the extended sources are routed to |
| ext_clr | input | 1 | Clears the pending bit shown on ext_id |
| take_irq | output | 1 | Take an interrupt now |
| take_lvl | output | 4 | Level to take; 0 when none |
| ext_id | output | 5 | Highest pending extended source number, or 0 |
| ext_any | output | 1 | Some extended source is pending |

## Verification
The assertions watch, on every cycle, the properties that hold at any single edge. An interrupt is taken only when traps were enabled. A taken level other than 15 lies above the mask that was in force. Level 15 always gets through when traps are enabled. A clear strobe hits at most one pending bit and leaves that bit at zero. A pending bit rises only after its synchronized request was high. Properties that depend on a history of inputs can only be shown by the bench's scenarios: that the highest eligible level wins across the full sweep of masks, enables and request patterns; the exact synchronizer latency; the sticky pending bits; the order in which identifiers appear as bits are cleared; and the handling of base levels 0 and 15.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int LVL_W   = 4;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int NMI_LVL = NUM_LVL - 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqarb_sync.sv
module irqarb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqarb_ext.sv
module irqarb_ext
  import irqarb_pkg::*;
#(
  parameter int SRC = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRC-1:0]           req_sync,
  input  logic                     clr,
  input  lvl_t                     base,
  output logic [NUM_LVL-1:1]       lvl_vec,
  output logic [$clog2(SRC):0]     id,
  output logic                     any
);
  localparam int IDX_W = $clog2(SRC);

  logic [SRC-1:0]   pend;
  logic [SRC-1:0]   clr_hit;
  logic [IDX_W-1:0] top_idx;
  logic             base_ok;

  // highest-numbered pending bit
  always_comb begin
    top_idx = '0;
    for (int i = 0; i < SRC; i++) begin
      if (pend[i]) top_idx = IDX_W'(i);
    end
  end

  assign any     = |pend;
  assign id      = any ? {1'b1, top_idx} : '0;
  assign clr_hit = (clr && any) ? (SRC'(1) << top_idx) : '0;
  assign base_ok = (base != lvl_t'(0)) && (base != lvl_t'(NMI_LVL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < SRC; i++) begin
        if (clr_hit[i]) pend[i] <= 1'b0;
        else if (req_sync[i]) pend[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    lvl_vec = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      lvl_vec[i] = any && base_ok && (base == lvl_t'(i));
    end
  end

  // R9
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_hit));

  for (genvar g = 0; g < SRC; g++) begin : g_pend_chk
    // R7
    pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[g]) |-> $past(req_sync[g]));
    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[g] |=> !pend[g]);
  end
endmodule

// File: rtl/irqarb_pick.sv
module irqarb_pick
  import irqarb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:1] req_vec,
  input  lvl_t               mask,
  input  logic               trap_en,
  output logic               take,
  output lvl_t               lvl
);
  logic [NUM_LVL-1:1] elig;
  lvl_t               sel;

  always_comb begin
    elig = '0;
    sel  = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      elig[i] = req_vec[i] && trap_en &&
                ((lvl_t'(i) > mask) || (i == NMI_LVL));
      if (elig[i]) sel = lvl_t'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take <= 1'b0;
      lvl  <= '0;
    end else begin
      take <= |elig;
      lvl  <= sel;
    end
  end

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(trap_en));
  // R3
  above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && lvl != lvl_t'(NMI_LVL)) |-> (lvl > $past(mask)));
  // R4
  nmi_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(trap_en) && $past(req_vec[NMI_LVL]) && $past(rst_n))
      |-> (take && lvl == lvl_t'(NMI_LVL)));
endmodule

// File: rtl/irqarb_top.sv
module irqarb_top
  import irqarb_pkg::*;
#(
  parameter int EXT_EN   = 1,
  parameter int EXT_SRC  = 16,
  parameter int SYNC_STG = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LVL-1:1]        irq_req,
  input  logic [LVL_W-1:0]          pil_mask,
  input  logic                      trap_en,
  input  logic [EXT_SRC-1:0]        ext_req,
  input  logic [LVL_W-1:0]          ext_base,
  input  logic                      ext_clr,
  output logic                      take_irq,
  output logic [LVL_W-1:0]          take_lvl,
  output logic [$clog2(EXT_SRC):0]  ext_id,
  output logic                      ext_any
);
  localparam int ID_W = $clog2(EXT_SRC) + 1;

  logic [NUM_LVL-1:1] irq_s;
  logic [NUM_LVL-1:1] ext_vec;
  logic [NUM_LVL-1:1] all_vec;

  irqarb_sync #(.W(NUM_LVL-1), .STAGES(SYNC_STG)) u_sync_lvl (
    .clk(clk), .rst_n(rst_n), .d(irq_req), .q(irq_s)
  );

  if (EXT_EN != 0) begin : g_ext
    logic [EXT_SRC-1:0] ext_s;

    irqarb_sync #(.W(EXT_SRC), .STAGES(SYNC_STG)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d(ext_req), .q(ext_s)
    );

    irqarb_ext #(.SRC(EXT_SRC)) u_ext (
      .clk(clk), .rst_n(rst_n), .req_sync(ext_s), .clr(ext_clr),
      .base(ext_base), .lvl_vec(ext_vec), .id(ext_id), .any(ext_any)
    );
  end else begin : g_noext
    assign ext_vec = '0;
    assign ext_id  = ID_W'(0);
    assign ext_any = 1'b0;
  end

  assign all_vec = irq_s | ext_vec;

  irqarb_pick u_pick (
    .clk(clk), .rst_n(rst_n), .req_vec(all_vec), .mask(pil_mask),
    .trap_en(trap_en), .take(take_irq), .lvl(take_lvl)
  );
endmodule

// File: tb/sim_irqarb_top.sv
module sim_irqarb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] irq_req = '0;
  logic [3:0]  pil_mask = '0;
  logic        trap_en = 1'b0;
  logic [15:0] ext_req = '0;
  logic [3:0]  ext_base = '0;
  logic        ext_clr = 1'b0;
  logic        take_irq;
  logic [3:0]  take_lvl;
  logic [4:0]  ext_id;
  logic        ext_any;

  int vecs = 0;
  int bad  = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irqarb_top u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .pil_mask(pil_mask),
    .trap_en(trap_en), .ext_req(ext_req), .ext_base(ext_base),
    .ext_clr(ext_clr), .take_irq(take_irq), .take_lvl(take_lvl),
    .ext_id(ext_id), .ext_any(ext_any)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int model(input logic [15:1] r, input int m, input bit te);
    int best = 0;
    if (!te) return 0;
    for (int i = 1; i < 16; i++) begin
      if (r[i] && (i > m || i == 15)) best = i;
    end
    return best;
  endfunction

  task automatic pulse_clr();
    ext_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    settle(3);
    // R1 during reset
    chk("R1 take", take_irq, 0);
    chk("R1 lvl", take_lvl, 0);
    chk("R1 id", ext_id, 0);
    chk("R1 any", ext_any, 0);
    rst_n = 1'b1;
    settle(1);
    chk("R1 take after release", take_irq, 0);

    // R6: request latency three edges
    trap_en = 1'b1;
    irq_req = 15'h0 | (15'(1) << 8); // level 9
    settle(2);
    chk("R6 not yet", take_irq, 0);
    settle(1);
    chk("R6 take", take_irq, 1);
    chk("R6 lvl", take_lvl, 9);
    // R6: mask change one edge
    pil_mask = 4'd9;
    settle(1);
    chk("R6 mask edge", take_irq, 0);

    // R2 R3 R4 R5 sweep
    for (int te = 0; te < 2; te++) begin
      for (int m = 0; m < 16; m++) begin
        for (int p = 0; p < 40; p++) begin
          logic [15:1] pat;
          int e;
          if (p < 15) pat = 15'(1) << p;
          else pat = 15'((p * 16'h9E37) ^ (p << 5) ^ (m * 16'h0321));
          irq_req  = pat;
          pil_mask = 4'(m);
          trap_en  = te[0];
          settle(3);
          e = model(pat, m, te[0]);
          if (te == 0)       chk("R5 blocked", take_lvl, e);
          else if (pat[15])  chk("R4 nmi", take_lvl, e);
          else if (p < 15)   chk("R3 mask", take_lvl, e);
          else               chk("R2 highest", take_lvl, e);
          chk("R2 take flag", take_irq, (e != 0) ? 1 : 0);
        end
      end
    end

    // extended stage
    irq_req = '0; pil_mask = 4'd0; trap_en = 1'b1; ext_base = 4'd5;
    settle(3);
    ext_req = 16'h0001;
    settle(2);
    chk("R11 pend not yet", ext_any, 0);
    settle(1);
    chk("R11 pend set", ext_any, 1);
    chk("R11 no take yet", take_irq, 0);
    settle(1);
    chk("R11 take", take_lvl, 5);
    chk("R8 id src16", ext_id, 16);
    ext_req = '0;
    settle(3);
    pulse_clr();
    chk("R9 cleared any", ext_any, 0);
    chk("R8 id none", ext_id, 0);

    ext_req = 16'h0208; // sources 19 and 25
    settle(4);
    chk("R7 take base", take_lvl, 5);
    chk("R8 highest id", ext_id, 25);
    ext_req = '0;
    settle(4);
    chk("R7 sticky", ext_id, 25);
    pulse_clr();
    chk("R9 next id", ext_id, 19);
    chk("R9 still any", ext_any, 1);
    settle(1);
    chk("R7 still taken", take_lvl, 5);

    pil_mask = 4'd5;
    settle(1);
    chk("R3 ext masked", take_irq, 0);
    pil_mask = 4'd0;
    irq_req = 15'(1) << 6; // level 7
    settle(3);
    chk("R2 ext vs lvl7", take_lvl, 7);
    irq_req = '0;
    ext_base = 4'd0;
    settle(3);
    chk("R10 base0 no take", take_irq, 0);
    chk("R10 base0 id", ext_id, 19);
    ext_base = 4'd15;
    settle(1);
    chk("R10 base15 no take", take_irq, 0);
    ext_base = 4'd14;
    settle(1);
    chk("R7 base14", take_lvl, 14);

    // R9: clear wins over simultaneous set, then bit re-sets
    ext_req = 16'h0008;
    settle(2);
    ext_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ext_clr = 1'b0;
    chk("R9 clear wins", ext_any, 0);
    settle(0);
    @(posedge clk); @(negedge clk);
    chk("R9 re-set", ext_id, 19);
    ext_req = '0;
    settle(3);
    pulse_clr();
    settle(1);
    chk("R9 all clear take", take_irq, 0);
    chk("R8 any zero", ext_any, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule